// File: doc/BRIEF.md
# LCD Common-Scan Timing Sequencer

This block produces the digital timing of a multiplexed LCD backplane. On every tick of a clock enable from the display oscillator it moves the active common line one step forward. It wraps after the last common that the selected duty uses. For the common that is active, it takes that common's column out of a flat display memory and presents it as per-segment "on" requests. Each wrap flips a frame-polarity bit. The analog stage downstream uses this bit for its frame-inversion waveform shaping.

A 2-bit duty code selects 8, 9 or 10 commons. Commons outside the selected set are flagged idle, which asks the analog stage for the parked bias-4 level. A new duty code is adopted only at a frame boundary, so a frame is never cut short. Blanking and sleep override the display in different ways:

- **Blanking** keeps the scan and polarity running and only withholds the segment "on" requests, so the segment outputs still toggle with an off waveform.
- **Sleep** parks every common and stops scanning. Scanning starts over from the first common when sleep ends.

An oscillator-run request and the general-purpose port outputs are also produced here. The general-purpose ports ignore sleep.

Top module: `lcd_com_scan`

## Requirements
- R1: The duty code selects the scanned commons. Code 2'b00 and the unused code 2'b11 scan commons 1..8 and flag commons 9 and 10 idle. Code 2'b10 scans commons 1..9 and flags common 10 idle. Code 2'b01 scans all 10 commons. Bit i of `comActive` and of `comIdle` belongs to common i+1.
- R2: Outside sleep, `comActive` is one-hot. Each clock cycle with `tickEn` high moves it to the next common, and a cycle without `tickEn` holds it.
- R3: `framePol` flips each time the scan wraps from the last scanned common back to common 1, and at no other time outside sleep.
- R4: A new duty code is loaded only when the scan wraps or while in sleep. Until then the previous common count, and its `comIdle` pattern, stay in force.
- R5: Outside sleep and blanking, `segOn[s]` equals `dispMem[c*SEG_COUNT+s]`, where c is the zero-based index of the active common.
- R6: While `segBlank` is high, `segOn` is all zero, but the common scan and `framePol` keep advancing exactly as without blanking.
- R7: While `sleepMode` is high, `comActive` is all zero, `comIdle` is all ones and `segOn` is all zero.
- R8: In the first cycle after `sleepMode` falls, common 1 is active and `framePol` is 0.
- R9: `oscRun` is high unless `sleepMode` is high and `keyScanBusy` is low.
- R10: `portOut` equals the `portSet` value of the previous clock cycle, whether or not sleep is active.
- R11: After reset, common 1 is active, `framePol` is 0, the count is 8 commons (commons 9 and 10 idle) and `portOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Scan-step clock enable from the oscillator |
| keyScanBusy | input | 1 | A key scan is in progress and needs the oscillator |
| dutySel | input | 2 | Duty code (00/11: 8, 10: 9, 01: 10 commons) |
| segBlank | input | 1 | Blank all segments while still scanning |
| sleepMode | input | 1 | Sleep: park outputs, stop scan |
| dispMem | input | MAX_COMS*SEG_COUNT | Display bits, common-major |
| portSet | input | PORT_W | General-purpose port settings |
| comActive | output | MAX_COMS | One-hot active-common strobe |
| comIdle | output | MAX_COMS | Common parked at the idle level |
| segOn | output | SEG_COUNT | Segment on requests for the active common |
| framePol | output | 1 | Frame polarity |
| oscRun | output | 1 | Oscillator run request |
| portOut | output | PORT_W | General-purpose port outputs |

## Verification
The bound checker covers these on every cycle:

- the one-hot strobe and its stepping on ticks;
- that polarity flips and idle-pattern changes happen only with common 1 active;
- the parked state in sleep and the restart after it;
- the silence of the segments under blanking;
- the oscillator request;
- the one-cycle port delay.

Only the bench's scenarios can show the following:

- the exact common count per duty code, including the unused code;
- that a mid-frame duty change waits for the boundary;
- that the right display column reaches `segOn` for each common;
- that scanning under blanking matches the unblanked sequence.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam logic [1:0] DUTY_EIGHT = 2'b00;
  localparam logic [1:0] DUTY_TEN   = 2'b01;
  localparam logic [1:0] DUTY_NINE  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // sleep: go to common 1, polarity cleared
    logic step;     // advance one common
    logic wrap;     // step that closes a frame
  } scanStrobe_t;

  // number of scanned commons for a duty code; the spare code falls back to 8
  function automatic int unsigned dutyCommons(input logic [1:0] code);
    case (code)
      DUTY_TEN:  return 10;
      DUTY_NINE: return 9;
      default:   return 8;
    endcase
  endfunction

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             sleepMode,
  input  logic [1:0]       dutySel,
  input  logic [IDX_W-1:0] comIdx,
  output scanStrobe_t      strobe,
  output logic [CNT_W-1:0] activeCount
);

  logic [CNT_W-1:0] nextCount;
  logic             lastCom;

  assign nextCount = CNT_W'(dutyCommons(dutySel));
  assign lastCom   = ({1'b0, comIdx} == (activeCount - CNT_W'(1)));

  always_comb begin
    strobe.restart = sleepMode;
    strobe.step    = !sleepMode && tickEn;
    strobe.wrap    = !sleepMode && tickEn && lastCom;
  end

  // duty is adopted only at a frame boundary or while parked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCount <= CNT_W'(dutyCommons(DUTY_EIGHT));
    end else if (strobe.restart || strobe.wrap) begin
      activeCount <= nextCount;
    end
  end

endmodule

// File: rtl/lcd_scan_dp.sv
module lcd_scan_dp
  import lcd_scan_pkg::*;
#(
  parameter int MAX_COMS  = 10,
  parameter int SEG_COUNT = 8,
  parameter int PORT_W    = 4,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = IDX_W + 1,
  localparam int MEM_W    = MAX_COMS * SEG_COUNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobe_t          strobe,
  input  logic [CNT_W-1:0]     activeCount,
  input  logic                 sleepMode,
  input  logic                 segBlank,
  input  logic [MEM_W-1:0]     dispMem,
  input  logic [PORT_W-1:0]    portSet,
  output logic [IDX_W-1:0]     comIdx,
  output logic [MAX_COMS-1:0]  comActive,
  output logic [MAX_COMS-1:0]  comIdle,
  output logic [SEG_COUNT-1:0] segOn,
  output logic                 framePol,
  output logic [PORT_W-1:0]    portOut
);

  logic [SEG_COUNT-1:0] column;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comIdx   <= '0;
      framePol <= 1'b0;
      portOut  <= '0;
    end else begin
      portOut <= portSet;
      if (strobe.restart) begin
        comIdx   <= '0;
        framePol <= 1'b0;
      end else if (strobe.wrap) begin
        comIdx   <= '0;
        framePol <= !framePol;
      end else if (strobe.step) begin
        comIdx <= comIdx + IDX_W'(1);
      end
    end
  end

  for (genvar c = 0; c < MAX_COMS; c++) begin : g_com
    assign comActive[c] = !sleepMode && (comIdx == IDX_W'(c));
    assign comIdle[c]   = sleepMode || (CNT_W'(c) >= activeCount);
  end

  assign column = dispMem[int'(comIdx) * SEG_COUNT +: SEG_COUNT];
  assign segOn  = (sleepMode || segBlank) ? '0 : column;

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int MAX_COMS  = 10,
  parameter int SEG_COUNT = 8,
  parameter int PORT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tickEn,
  input  logic                          keyScanBusy,
  input  logic [1:0]                    dutySel,
  input  logic                          segBlank,
  input  logic                          sleepMode,
  input  logic [MAX_COMS*SEG_COUNT-1:0] dispMem,
  input  logic [PORT_W-1:0]             portSet,
  output logic [MAX_COMS-1:0]           comActive,
  output logic [MAX_COMS-1:0]           comIdle,
  output logic [SEG_COUNT-1:0]          segOn,
  output logic                          framePol,
  output logic                          oscRun,
  output logic [PORT_W-1:0]             portOut
);

  localparam int IDX_W = $clog2(MAX_COMS);
  localparam int CNT_W = IDX_W + 1;

  scanStrobe_t      strobe;
  logic [IDX_W-1:0] comIdx;
  logic [CNT_W-1:0] activeCount;

  // a key scan keeps the oscillator alive through sleep
  assign oscRun = !sleepMode || keyScanBusy;

  lcd_scan_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sleepMode(sleepMode),
    .dutySel(dutySel), .comIdx(comIdx), .strobe(strobe),
    .activeCount(activeCount)
  );

  lcd_scan_dp #(
    .MAX_COMS(MAX_COMS), .SEG_COUNT(SEG_COUNT), .PORT_W(PORT_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .activeCount(activeCount),
    .sleepMode(sleepMode), .segBlank(segBlank), .dispMem(dispMem),
    .portSet(portSet), .comIdx(comIdx), .comActive(comActive),
    .comIdle(comIdle), .segOn(segOn), .framePol(framePol),
    .portOut(portOut)
  );

endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
  parameter int MAX_COMS  = 10,
  parameter int SEG_COUNT = 8,
  parameter int PORT_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickEn,
  input logic                 keyScanBusy,
  input logic                 segBlank,
  input logic                 sleepMode,
  input logic [PORT_W-1:0]    portSet,
  input logic [MAX_COMS-1:0]  comActive,
  input logic [MAX_COMS-1:0]  comIdle,
  input logic [SEG_COUNT-1:0] segOn,
  input logic                 framePol,
  input logic                 oscRun,
  input logic [PORT_W-1:0]    portOut
);

  // R2
  one_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleepMode |-> $onehot(comActive) && ((comActive & comIdle) == '0));

  // R2
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleepMode && tickEn |=> sleepMode || (comActive != $past(comActive)));

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleepMode && !tickEn |=> sleepMode || $stable(comActive));

  // R3
  pol_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (framePol != $past(framePol)) && !$past(sleepMode)
      |-> comActive[0] || sleepMode);

  // R4
  duty_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleepMode && !$past(sleepMode) && (comIdle != $past(comIdle))
      |-> comActive[0]);

  // R6
  blank_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    segBlank |-> segOn == '0);

  // R7
  sleep_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepMode |-> (comActive == '0) && (segOn == '0) && (&comIdle));

  // R8
  wake_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepMode) |-> comActive[0] && !framePol);

  // R9
  osc_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyScanBusy || !sleepMode |-> oscRun);

  // R9
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepMode && !keyScanBusy |-> !oscRun);

  // R10
  port_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> portOut == $past(portSet));

endmodule

bind lcd_com_scan lcd_com_scan_chk #(
  .MAX_COMS(MAX_COMS), .SEG_COUNT(SEG_COUNT), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .keyScanBusy(keyScanBusy),
  .segBlank(segBlank), .sleepMode(sleepMode), .portSet(portSet),
  .comActive(comActive), .comIdle(comIdle), .segOn(segOn),
  .framePol(framePol), .oscRun(oscRun), .portOut(portOut)
);

// File: tb/lcd_com_scan_tb.sv
`timescale 1ns/1ps
module lcd_com_scan_tb;

  localparam int NC = 10;
  localparam int NS = 8;
  localparam int NP = 4;

  typedef struct {
    string          tag;
    logic [NC-1:0]  act;
    logic [NC-1:0]  idle;
    logic [NS-1:0]  seg;
    logic           pol;
    logic           osc;
    logic [NP-1:0]  port;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, keyScanBusy = 1'b0, segBlank = 1'b0, sleepMode = 1'b0;
  logic [1:0] dutySel = 2'b00;
  logic [NC*NS-1:0] dispMem = '0;
  logic [NP-1:0] portSet = '0;
  logic [NC-1:0] comActive, comIdle;
  logic [NS-1:0] segOn;
  logic framePol, oscRun;
  logic [NP-1:0] portOut;

  // stimulus values applied by the driver
  logic bSleep = 0, bBlank = 0, bKey = 0;
  logic [1:0] bDuty = 2'b00;
  logic [NC*NS-1:0] bMem = 80'h3C5A_96F0_0F12_34AB_CD99;
  logic [NP-1:0] bPort = '0;

  // reference state from the requirements
  int mIdx = 0, mCount = 8;
  logic mPol = 0;
  logic [NP-1:0] mPrevPort = '0;

  expItem_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_com_scan #(.MAX_COMS(NC), .SEG_COUNT(NS), .PORT_W(NP)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .keyScanBusy(keyScanBusy),
    .dutySel(dutySel), .segBlank(segBlank), .sleepMode(sleepMode),
    .dispMem(dispMem), .portSet(portSet), .comActive(comActive),
    .comIdle(comIdle), .segOn(segOn), .framePol(framePol),
    .oscRun(oscRun), .portOut(portOut)
  );

  function automatic int commonsFor(input logic [1:0] code);
    if (code == 2'b01) return 10;
    if (code == 2'b10) return 9;
    return 8;
  endfunction

  task automatic drive(input logic tick, input string tag);
    expItem_t e;
    @(posedge clk);
    #2;
    tickEn = tick; sleepMode = bSleep; segBlank = bBlank;
    keyScanBusy = bKey; dutySel = bDuty; dispMem = bMem; portSet = bPort;
    e.tag  = tag;
    e.act  = bSleep ? '0 : (NC'(1) << mIdx);
    for (int c = 0; c < NC; c++) e.idle[c] = bSleep || (c >= mCount);
    e.seg  = (bSleep || bBlank) ? '0 : bMem[mIdx*NS +: NS];
    e.pol  = mPol;
    e.osc  = !bSleep || bKey;
    e.port = mPrevPort;
    q.push_back(e);
    // state after the coming edge
    mPrevPort = bPort;
    if (bSleep) begin
      mIdx = 0; mPol = 0; mCount = commonsFor(bDuty);
    end else if (tick) begin
      if (mIdx == mCount - 1) begin
        mIdx = 0; mPol = !mPol; mCount = commonsFor(bDuty);
      end else begin
        mIdx = mIdx + 1;
      end
    end
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per driven cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        cmp(e.tag, "comActive", 32'(comActive), 32'(e.act));
        cmp(e.tag, "comIdle",   32'(comIdle),   32'(e.idle));
        cmp(e.tag, "segOn",     32'(segOn),     32'(e.seg));
        cmp(e.tag, "framePol",  32'(framePol),  32'(e.pol));
        cmp(e.tag, "oscRun",    32'(oscRun),    32'(e.osc));
        cmp(e.tag, "portOut",   32'(portOut),   32'(e.port));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    drive(0, "R11");
    drive(0, "R11");
    // 8-common duty, full frames
    repeat (10) drive(1, "R2");
    repeat (10) drive(1, "R3");
    bPort = 4'h5;
    repeat (8) drive(1, "R5");
    // duty change mid-frame waits for wrap
    drive(1, "R4");
    bDuty = 2'b01;
    repeat (8) drive(1, "R4");
    repeat (22) drive(1, "R1");
    bDuty = 2'b10;
    bMem = 80'hF0E1_D2C3_B4A5_9687_7869;
    repeat (24) drive(1, "R1");
    bDuty = 2'b11;
    repeat (22) drive(1, "R1");
    // blanking keeps scanning
    bBlank = 1;
    repeat (12) drive(1, "R6");
    bBlank = 0;
    repeat (8) begin
      drive(1, "R2");
      drive(0, "R2");
    end
    // sleep
    bSleep = 1; bDuty = 2'b01;
    repeat (3) drive(1, "R7");
    bKey = 1;
    drive(0, "R9");
    bPort = 4'h9;
    drive(1, "R10");
    bPort = 4'h6;
    drive(0, "R10");
    bKey = 0;
    drive(1, "R9");
    bSleep = 0;
    drive(0, "R8");
    repeat (24) drive(1, "R8");

    @(negedge clk);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule